// File: doc/BRIEF.md
# Sigma-Delta Fast Threshold Comparator

This block is the low-latency protection path for one sigma-delta channel. It accepts a one-bit modulator stream with a qualifying valid strobe and runs it through a short sinc decimation filter. The filter shape is chosen from four variants and the decimation ratio from 1 to 32. Each settled filter output is clamped to the unsigned threshold range. It is then compared against three thresholds. Two of the comparisons latch sticky over-value and under-value flags, and these may raise an interrupt request. The third drives a live crossing output that never interrupts.

The block is meant to sit beside a slower, higher-resolution data filter and trip protection logic within a few modulator bits of an excursion. Changing the filter shape or ratio restarts the filter from an empty history. The sticky flags survive that restart and clear only on an explicit one-cycle clear pulse.

Top module: `sdcmp_fast_monitor`

## Requirements
- R1: `ftype_i` selects the filter: 0 = fast (sum of the last 2·N bits, where N = `ratio_i`+1), 1 = first-order sinc, 2 = second-order sinc, 3 = third-order sinc. The decimation factor is N. One result is formed per N bits accepted with `bit_vld_i` high, and cycles with `bit_vld_i` low are ignored.
- R2: An order-k sinc result equals the convolution of the unipolar bits (1 counts as one, 0 as zero) with k cascaded length-N boxcars. The convolution is taken over all bits since the last restart, with earlier bits counting as zero.
- R3: A result above 32767 is presented as 32767 on `cmp_data_o`. A result at or below 32767 is presented unchanged.
- R4: A result is published (`cmp_vld_o` high for one cycle, `cmp_data_o` updated) only once the filter window is full. For the sinc filters that means from the k-th decimation period on. For the fast filter it means from the 2nd period on.
- R5: Any change of `ftype_i` or `ratio_i` restarts the filter with an empty history and restarts the settling count. The sticky flags and the crossing output are kept.
- R6: `hi_flag_o` is set by a published value greater than or equal to `hi_thr_i`, and it stays set until cleared.
- R7: `lo_flag_o` is set by a published value less than or equal to `lo_thr_i`, and it stays set until cleared.
- R8: A one-cycle `clr_i` pulse clears both sticky flags. When a publication that sets a flag falls in the same cycle as the clear, the flag ends set.
- R9: `cross_o` takes the value (published value >= `cross_thr_i`) at every publication and holds it between publications. It has no effect on `irq_o`.
- R10: `irq_o` is high exactly when (`hi_flag_o` and `hi_en_i`) or (`lo_flag_o` and `lo_en_i`). The flags set regardless of the enables.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Modulator bit |
| bit_vld_i | input | 1 | Qualifies `bit_i` for one cycle |
| ftype_i | input | 2 | Filter shape select (see R1) |
| ratio_i | input | RATIO_W (5) | Decimation factor minus one |
| hi_thr_i | input | THR_W (15) | Over-value threshold, inclusive |
| lo_thr_i | input | THR_W (15) | Under-value threshold, inclusive |
| cross_thr_i | input | THR_W (15) | Crossing-output threshold, inclusive |
| hi_en_i | input | 1 | Lets the over-value flag reach `irq_o` |
| lo_en_i | input | 1 | Lets the under-value flag reach `irq_o` |
| clr_i | input | 1 | One-cycle clear of both sticky flags |
| cmp_data_o | output | THR_W (15) | Last published, clamped filter value |
| cmp_vld_o | output | 1 | One-cycle strobe for a new published value |
| hi_flag_o | output | 1 | Sticky over-value flag |
| lo_flag_o | output | 1 | Sticky under-value flag |
| cross_o | output | 1 | Live crossing comparison |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a clear pulse landing in exactly the cycle that a flag-setting result is published. Only then can the set-wins rule be seen. The bench reaches it by ending a decimation period with a single valid bit and raising `clr_i` on the very next cycle. That cycle is the one in which the comb stage hands its result to the comparators. The clamp at 32767 is the other awkward corner. It appears only with the third-order filter at the largest ratio fed with a full window of ones, so the bench drives exactly that. It also drives the ratio one step lower to show the unclamped maximum of 29791.

// File: rtl/sdcmp_pkg.sv
package sdcmp_pkg;

   typedef enum logic [1:0] {
      FT_FAST  = 2'd0,
      FT_SINC1 = 2'd1,
      FT_SINC2 = 2'd2,
      FT_SINC3 = 2'd3
   } sdcmp_ftype_e;

   // highest sinc order supported: integrator and comb depth
   localparam int unsigned SDCMP_STAGES = 3;

   // decimation periods needed before the window is full
   function automatic int unsigned sdcmp_need(input sdcmp_ftype_e ft);
      case (ft)
         FT_FAST:  return 2;
         FT_SINC1: return 1;
         FT_SINC2: return 2;
         default:  return 3;
      endcase
   endfunction

endpackage

// File: rtl/sdcmp_integ.sv
module sdcmp_integ #(
   parameter int unsigned ACC_W  = 16,
   parameter int unsigned STAGES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             bit_i,
   input  logic             bit_vld_i,
   output logic [ACC_W-1:0] acc_o [STAGES]
);

   logic [ACC_W-1:0] nxt [STAGES];

   genvar k;
   generate
      for (k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            assign nxt[k] = acc_o[k] + {{(ACC_W-1){1'b0}}, bit_i};
         end else begin : g_chain
            assign nxt[k] = acc_o[k] + nxt[k-1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_o[k] <= '0;
            end else if (restart_i) begin
               acc_o[k] <= '0;
            end else if (bit_vld_i) begin
               acc_o[k] <= nxt[k];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sdcmp_decim.sv
module sdcmp_decim #(
   parameter int unsigned RATIO_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart_i,
   input  logic               bit_vld_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               stb_o
);

   logic [RATIO_W-1:0] cnt_q;
   logic               last;

   assign last = (cnt_q == ratio_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         stb_o <= 1'b0;
      end else if (restart_i) begin
         cnt_q <= '0;
         stb_o <= 1'b0;
      end else begin
         stb_o <= bit_vld_i && last;
         if (bit_vld_i) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sdcmp_comb.sv
module sdcmp_comb
   import sdcmp_pkg::*;
#(
   parameter int unsigned ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             stb_i,
   input  sdcmp_ftype_e     ftype_i,
   input  logic [ACC_W-1:0] acc_i [SDCMP_STAGES],
   output logic [ACC_W-1:0] res_o,
   output logic             pub_o
);

   logic [ACC_W-1:0] s [SDCMP_STAGES+1];
   logic [ACC_W-1:0] dly_q [SDCMP_STAGES];
   logic [ACC_W-1:0] dly_x_q;
   logic [1:0]       seen_q;

   // tap the integrator whose depth matches the filter order
   always_comb begin
      case (ftype_i)
         FT_SINC2: s[0] = acc_i[1];
         FT_SINC3: s[0] = acc_i[2];
         default:  s[0] = acc_i[0];
      endcase
   end

   genvar k;
   generate
      for (k = 0; k < SDCMP_STAGES; k++) begin : g_diff
         assign s[k+1] = s[k] - dly_q[k];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dly_q[k] <= '0;
            end else if (restart_i) begin
               dly_q[k] <= '0;
            end else if (stb_i) begin
               dly_q[k] <= s[k];
            end
         end
      end
   endgenerate

   // second decimated delay: the fast shape differences over two periods
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_x_q <= '0;
      end else if (restart_i) begin
         dly_x_q <= '0;
      end else if (stb_i) begin
         dly_x_q <= dly_q[0];
      end
   end

   always_comb begin
      case (ftype_i)
         FT_FAST:  res_o = s[0] - dly_x_q;
         FT_SINC1: res_o = s[1];
         FT_SINC2: res_o = s[2];
         default:  res_o = s[3];
      endcase
   end

   // count decimation periods since restart until the window is full
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
      end else if (restart_i) begin
         seen_q <= '0;
      end else if (stb_i && seen_q != 2'd3) begin
         seen_q <= seen_q + 2'd1;
      end
   end

   assign pub_o = stb_i && !restart_i &&
                  ((32'(seen_q) + 32'd1) >= sdcmp_need(ftype_i));

endmodule

// File: rtl/sdcmp_thresh.sv
module sdcmp_thresh #(
   parameter int unsigned ACC_W = 16,
   parameter int unsigned THR_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pub_i,
   input  logic [ACC_W-1:0] res_i,
   input  logic [THR_W-1:0] hi_thr_i,
   input  logic [THR_W-1:0] lo_thr_i,
   input  logic [THR_W-1:0] cross_thr_i,
   input  logic             hi_en_i,
   input  logic             lo_en_i,
   input  logic             clr_i,
   output logic [THR_W-1:0] data_o,
   output logic             vld_o,
   output logic             hi_flag_o,
   output logic             lo_flag_o,
   output logic             cross_o,
   output logic             irq_o
);

   logic [THR_W-1:0] val;
   logic             hi_hit;
   logic             lo_hit;
   logic             x_hit;

   generate
      if (ACC_W > THR_W) begin : g_clamp
         localparam logic [ACC_W-1:0] CEIL = ACC_W'({THR_W{1'b1}});
         assign val = (res_i > CEIL) ? {THR_W{1'b1}} : res_i[THR_W-1:0];
      end else begin : g_direct
         assign val = res_i[THR_W-1:0];
      end
   endgenerate

   assign hi_hit = (val >= hi_thr_i);
   assign lo_hit = (val <= lo_thr_i);
   assign x_hit  = (val >= cross_thr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o    <= '0;
         vld_o     <= 1'b0;
         hi_flag_o <= 1'b0;
         lo_flag_o <= 1'b0;
         cross_o   <= 1'b0;
      end else begin
         vld_o     <= pub_i;
         hi_flag_o <= (pub_i && hi_hit) || (hi_flag_o && !clr_i);
         lo_flag_o <= (pub_i && lo_hit) || (lo_flag_o && !clr_i);
         if (pub_i) begin
            data_o  <= val;
            cross_o <= x_hit;
         end
      end
   end

   assign irq_o = (hi_flag_o && hi_en_i) || (lo_flag_o && lo_en_i);

endmodule

// File: rtl/sdcmp_fast_monitor.sv
module sdcmp_fast_monitor
   import sdcmp_pkg::*;
#(
   parameter int unsigned RATIO_W = 5,
   parameter int unsigned THR_W   = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_i,
   input  logic               bit_vld_i,
   input  logic [1:0]         ftype_i,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic [THR_W-1:0]   hi_thr_i,
   input  logic [THR_W-1:0]   lo_thr_i,
   input  logic [THR_W-1:0]   cross_thr_i,
   input  logic               hi_en_i,
   input  logic               lo_en_i,
   input  logic               clr_i,
   output logic [THR_W-1:0]   cmp_data_o,
   output logic               cmp_vld_o,
   output logic               hi_flag_o,
   output logic               lo_flag_o,
   output logic               cross_o,
   output logic               irq_o
);

   // third-order growth of a ratio up to 2**RATIO_W, plus one bit
   localparam int unsigned ACC_W = SDCMP_STAGES * RATIO_W + 1;
   localparam int unsigned CFG_W = 2 + RATIO_W;

   generate
      if (RATIO_W < 1 || RATIO_W > 8) begin : g_bad_ratio
         $error("sdcmp_fast_monitor: RATIO_W must lie in 1..8");
      end
      if (THR_W < 2 || THR_W > ACC_W) begin : g_bad_thr
         $error("sdcmp_fast_monitor: THR_W must lie in 2..ACC_W");
      end
   endgenerate

   sdcmp_ftype_e     ftype;
   logic [CFG_W-1:0] cfg_q;
   logic             restart;
   logic [ACC_W-1:0] acc [SDCMP_STAGES];
   logic             stb;
   logic [ACC_W-1:0] res;
   logic             pub;

   assign ftype   = sdcmp_ftype_e'(ftype_i);
   assign restart = ({ftype_i, ratio_i} != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         cfg_q <= {ftype_i, ratio_i};
      end
   end

   sdcmp_integ #(
      .ACC_W  (ACC_W),
      .STAGES (SDCMP_STAGES)
   ) i_integ (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .bit_i     (bit_i),
      .bit_vld_i (bit_vld_i),
      .acc_o     (acc)
   );

   sdcmp_decim #(
      .RATIO_W (RATIO_W)
   ) i_decim (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .bit_vld_i (bit_vld_i),
      .ratio_i   (ratio_i),
      .stb_o     (stb)
   );

   sdcmp_comb #(
      .ACC_W (ACC_W)
   ) i_comb (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .stb_i     (stb),
      .ftype_i   (ftype),
      .acc_i     (acc),
      .res_o     (res),
      .pub_o     (pub)
   );

   sdcmp_thresh #(
      .ACC_W (ACC_W),
      .THR_W (THR_W)
   ) i_thresh (
      .clk         (clk),
      .rst_n       (rst_n),
      .pub_i       (pub),
      .res_i       (res),
      .hi_thr_i    (hi_thr_i),
      .lo_thr_i    (lo_thr_i),
      .cross_thr_i (cross_thr_i),
      .hi_en_i     (hi_en_i),
      .lo_en_i     (lo_en_i),
      .clr_i       (clr_i),
      .data_o      (cmp_data_o),
      .vld_o       (cmp_vld_o),
      .hi_flag_o   (hi_flag_o),
      .lo_flag_o   (lo_flag_o),
      .cross_o     (cross_o),
      .irq_o       (irq_o)
   );

endmodule

// File: rtl/sdcmp_fast_monitor_chk.sv
module sdcmp_fast_monitor_chk #(
   parameter int unsigned THR_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_i,
   input logic [THR_W-1:0] hi_thr_i,
   input logic [THR_W-1:0] lo_thr_i,
   input logic [THR_W-1:0] cmp_data_o,
   input logic             cmp_vld_o,
   input logic             hi_flag_o,
   input logic             lo_flag_o,
   input logic             cross_o,
   input logic             irq_o
);

   a_r6_hi_set_by_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_flag_o) |-> cmp_vld_o && (cmp_data_o >= $past(hi_thr_i)));

   a_r7_lo_set_by_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_flag_o) |-> cmp_vld_o && (cmp_data_o <= $past(lo_thr_i)));

   a_r6_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hi_flag_o) |-> $past(clr_i));

   a_r7_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lo_flag_o) |-> $past(clr_i));

   a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (!hi_flag_o && !lo_flag_o) || cmp_vld_o);

   a_r9_cross_on_publish: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cross_o) |-> cmp_vld_o);

   a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_flag_o && !lo_flag_o) |-> !irq_o);

endmodule

bind sdcmp_fast_monitor sdcmp_fast_monitor_chk #(.THR_W(THR_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr_i      (clr_i),
   .hi_thr_i   (hi_thr_i),
   .lo_thr_i   (lo_thr_i),
   .cmp_data_o (cmp_data_o),
   .cmp_vld_o  (cmp_vld_o),
   .hi_flag_o  (hi_flag_o),
   .lo_flag_o  (lo_flag_o),
   .cross_o    (cross_o),
   .irq_o      (irq_o)
);

// File: tb/test_sdcmp_fast_monitor.sv
module test_sdcmp_fast_monitor;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_i = 1'b0;
   logic        bit_vld_i = 1'b0;
   logic [1:0]  ftype_i = 2'd0;
   logic [4:0]  ratio_i = 5'd0;
   logic [14:0] hi_thr_i = 15'h7fff;
   logic [14:0] lo_thr_i = 15'd0;
   logic [14:0] cross_thr_i = 15'h7fff;
   logic        hi_en_i = 1'b0;
   logic        lo_en_i = 1'b0;
   logic        clr_i = 1'b0;
   logic [14:0] cmp_data_o;
   logic        cmp_vld_o;
   logic        hi_flag_o;
   logic        lo_flag_o;
   logic        cross_o;
   logic        irq_o;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   logic hist [0:1023];
   int   nb = 0;
   int   cap [0:63];
   int   cap_n = 0;
   int   kern [0:127];
   int   klen = 0;
   logic [15:0] lfsr = 16'hACE1;

   sdcmp_fast_monitor i_sdcmp_fast_monitor (
      .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
      .ftype_i(ftype_i), .ratio_i(ratio_i), .hi_thr_i(hi_thr_i),
      .lo_thr_i(lo_thr_i), .cross_thr_i(cross_thr_i), .hi_en_i(hi_en_i),
      .lo_en_i(lo_en_i), .clr_i(clr_i), .cmp_data_o(cmp_data_o),
      .cmp_vld_o(cmp_vld_o), .hi_flag_o(hi_flag_o), .lo_flag_o(lo_flag_o),
      .cross_o(cross_o), .irq_o(irq_o)
   );

   always #2 clk = ~clk;

   always @(negedge clk) begin
      if (rst_n && cmp_vld_o && cap_n < 64) begin
         cap[cap_n] = int'(cmp_data_o);
         cap_n = cap_n + 1;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic next_bit();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   function automatic void build_kernel(input int ft, input int osr);
      int tmp [0:127];
      if (ft == 0) begin
         klen = 2 * osr;
         for (int m = 0; m < klen; m++) kern[m] = 1;
      end else begin
         klen = 1;
         kern[0] = 1;
         for (int o = 0; o < ft; o++) begin
            for (int m = 0; m < klen + osr - 1; m++) begin
               tmp[m] = 0;
               for (int t = 0; t < osr; t++)
                  if (m - t >= 0 && m - t < klen) tmp[m] += kern[m-t];
            end
            klen = klen + osr - 1;
            for (int m = 0; m < klen; m++) kern[m] = tmp[m];
         end
      end
   endfunction

   function automatic int expect_at(input int n);
      int sum = 0;
      for (int m = 0; m < klen; m++)
         if (n - 1 - m >= 0 && hist[n-1-m]) sum += kern[m];
      return (sum > 32767) ? 32767 : sum;
   endfunction

   task automatic set_cfg(input int ft, input int ra);
      @(negedge clk);
      bit_vld_i = 1'b0;
      ftype_i = 2'(ft);
      ratio_i = 5'(ra) ^ 5'd1;
      @(negedge clk);
      ratio_i = 5'(ra);
      @(negedge clk);
      @(negedge clk);
      nb = 0;
      cap_n = 0;
   endtask

   // gap 0 keeps the valid strobe high into the next bit
   task automatic send_bit(input logic b, input int gap);
      @(negedge clk);
      bit_i = b;
      bit_vld_i = 1'b1;
      hist[nb] = b;
      nb++;
      if (gap > 0) begin
         @(negedge clk);
         bit_vld_i = 1'b0;
         repeat (gap - 1) @(negedge clk);
      end
   endtask

   task automatic send_period(input int ones, input int osr);
      for (int i = 0; i < osr; i++) send_bit(i < ones, 1);
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      clr_i = 1'b1;
      @(negedge clk);
      clr_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_stream(input string req, input int ft, input int ra,
                             input int periods, input int gap, input bit ones);
      int osr = ra + 1;
      int need = (ft == 0) ? 2 : ft;
      set_cfg(ft, ra);
      for (int p = 0; p < periods; p++)
         for (int i = 0; i < osr; i++) send_bit(ones ? 1'b1 : next_bit(), gap);
      @(negedge clk);
      bit_vld_i = 1'b0;
      repeat (3) @(negedge clk);
      build_kernel(ft, osr);
      check(req, "publication count", cap_n, periods - need + 1);
      for (int j = need; j <= periods; j++)
         check(req, $sformatf("value of period %0d", j), cap[j-need], expect_at(j * osr));
   endtask

   task automatic test_reset();
      check("R11", "cmp_data_o", int'(cmp_data_o), 0);
      check("R11", "flags", int'({cmp_vld_o, hi_flag_o, lo_flag_o, cross_o, irq_o}), 0);
   endtask

   task automatic test_settle();
      set_cfg(3, 3);
      for (int i = 0; i < 8; i++) send_bit(1'b1, 1);
      repeat (3) @(negedge clk);
      check("R4", "sinc3 before third period", cap_n, 0);
      for (int i = 0; i < 4; i++) send_bit(1'b1, 1);
      repeat (3) @(negedge clk);
      check("R4", "sinc3 at third period", cap_n, 1);
      check("R4", "sinc3 full window value", cap[0], 64);
   endtask

   task automatic test_thresholds();
      set_cfg(1, 9);
      hi_thr_i = 15'd6; lo_thr_i = 15'd5; cross_thr_i = 15'h7fff;
      pulse_clr();
      send_period(6, 10);
      check("R6", "hi equal to threshold", int'(hi_flag_o), 1);
      check("R7", "lo above threshold", int'(lo_flag_o), 0);
      check("R2", "sinc1 count of ones", int'(cmp_data_o), 6);
      pulse_clr();
      hi_thr_i = 15'd7; lo_thr_i = 15'd6;
      send_period(6, 10);
      check("R6", "hi below threshold", int'(hi_flag_o), 0);
      check("R7", "lo equal to threshold", int'(lo_flag_o), 1);
      send_period(0, 10);
      lo_thr_i = 15'd0;
      send_period(9, 10);
      check("R7", "lo kept after later miss", int'(lo_flag_o), 1);
   endtask

   task automatic test_clear();
      set_cfg(1, 9);
      hi_thr_i = 15'd3; lo_thr_i = 15'd0;
      pulse_clr();
      send_period(6, 10);
      check("R8", "hi set before clear", int'(hi_flag_o), 1);
      pulse_clr();
      check("R8", "hi after clear", int'(hi_flag_o), 0);
      for (int i = 0; i < 10; i++) send_bit(i < 6, 1);
      clr_i = 1'b1;
      @(negedge clk);
      clr_i = 1'b0;
      repeat (2) @(negedge clk);
      check("R8", "set wins over same-cycle clear", int'(hi_flag_o), 1);
   endtask

   task automatic test_cross();
      set_cfg(1, 9);
      hi_thr_i = 15'h7fff; lo_thr_i = 15'd0; cross_thr_i = 15'd5;
      hi_en_i = 1'b1; lo_en_i = 1'b1;
      pulse_clr();
      send_period(6, 10);
      check("R9", "cross above threshold", int'(cross_o), 1);
      check("R9", "irq untouched by crossing", int'(irq_o), 0);
      send_period(5, 10);
      check("R9", "cross equal to threshold", int'(cross_o), 1);
      send_period(3, 10);
      check("R9", "cross falls with live value", int'(cross_o), 0);
      check("R9", "no sticky from crossing", int'({hi_flag_o, lo_flag_o, irq_o}), 0);
   endtask

   task automatic test_irq();
      set_cfg(1, 9);
      hi_en_i = 1'b0; lo_en_i = 1'b0;
      hi_thr_i = 15'd1; lo_thr_i = 15'd10; cross_thr_i = 15'h7fff;
      pulse_clr();
      send_period(6, 10);
      check("R10", "flags set while disabled", int'({hi_flag_o, lo_flag_o}), 3);
      check("R10", "irq while disabled", int'(irq_o), 0);
      hi_en_i = 1'b1;
      @(negedge clk);
      check("R10", "irq with hi enabled", int'(irq_o), 1);
      hi_en_i = 1'b0; lo_en_i = 1'b1;
      @(negedge clk);
      check("R10", "irq with lo enabled", int'(irq_o), 1);
      lo_en_i = 1'b0;
   endtask

   task automatic test_retain();
      check("R5", "flags before restart", int'({hi_flag_o, lo_flag_o}), 3);
      set_cfg(2, 4);
      repeat (2) @(negedge clk);
      check("R5", "flags kept over restart", int'({hi_flag_o, lo_flag_o}), 3);
      run_stream("R5", 2, 3, 5, 1, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      run_stream("R1", 1, 7, 6, 1, 1'b0);
      run_stream("R2", 2, 4, 6, 0, 1'b0);
      run_stream("R2", 3, 3, 6, 2, 1'b0);
      run_stream("R1", 0, 3, 6, 0, 1'b0);
      run_stream("R1", 1, 0, 12, 0, 1'b0);
      run_stream("R3", 3, 31, 4, 0, 1'b1);
      run_stream("R3", 3, 30, 3, 0, 1'b1);
      test_settle();
      test_thresholds();
      test_clear();
      test_cross();
      test_irq();
      test_retain();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule